// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations for a core's memory pipeline. The cache is direct-mapped. Every slot holds one physical page number that all access kinds share. Each slot also holds three separate virtual-page tags: one for loads, one for stores and one for instruction fetches. A lookup hits only when the tag for the requested access kind matches. A page that has been proven readable is therefore not assumed to be writable or executable until a walk for that kind has succeeded.

The requester holds a request (virtual address plus store and fetch flags) until the block raises a response with the physical address or an access-fault code. On a miss the block sends the virtual page number to an external page-table walker through a valid/ready handshake. It then waits for the walker's page number, answers in the same cycle that page number arrives, and installs it. When translation is off, or when machine-privilege rules say the address is already physical, the block answers at once. In that case it only checks the address against a memory size limit. A global flush invalidates every tag in one cycle.

Top module: `split_xlate_cache`

## Requirements
- R1: After reset every tag is invalid, no response and no walk request are raised, and the first translated access of any kind issues a walk.
- R2: A translated request whose own-kind tag at its slot equals its virtual page number (address bits 38:12) is answered in the same cycle with physical address {stored page number, address bits 11:0} and no walk.
- R3: The slot is the virtual page number modulo ENTRIES (its low bits), so two pages with equal low bits evict each other.
- R4: The load, store and fetch tags are independent: filling one kind does not make another kind hit on a page it has never walked.
- R5: On install, each of the three tags at the slot that differs from the new page is invalidated, a tag already equal to it is kept, and only the tag of the access's own kind is written.
- R6: A request with both store and fetch flags set is treated as a fetch: it uses and fills the fetch tag and faults as an instruction access.
- R7: On a miss, walk_req_valid_o stays high with a stable page number until walk_req_ready_i; the response comes in the cycle walk_rsp_valid_i is high, with the returned page number joined to the 12-bit page offset.
- R8: Bypass applies when bare_i is set, or when priv_mach_i is set together with eff_mach_i or a fetch. It answers in the same cycle with the address's own page base plus offset, issues no walk and leaves the tags unchanged.
- R9: In bypass, an address at or above mem_limit_i faults; one below it does not.
- R10: A walker result of all-ones page number is a fault; nothing is installed, so a repeat of the access walks again.
- R11: resp_kind_o is 0 on success, 1 for a load access fault, 2 for a store access fault and 3 for an instruction access fault; resp_paddr_o is 0 on a fault.
- R12: flush_i invalidates all tags of all three kinds in one cycle, and it wins over an install in the same cycle.
- R13: The all-ones virtual page number is the invalid tag value and never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate every tag |
| bare_i | input | 1 | Translation off |
| priv_mach_i | input | 1 | Current privilege is machine |
| eff_mach_i | input | 1 | Effective data privilege is machine |
| mem_limit_i | input | VA_W | Physical memory size used by the bypass check |
| req_valid_i | input | 1 | Request present (held until response) |
| req_vaddr_i | input | VA_W | Virtual address |
| req_store_i | input | 1 | Access is a store |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| resp_valid_o | output | 1 | Response for the held request |
| resp_paddr_o | output | PA_W | Physical address |
| resp_kind_o | output | 2 | Fault code (0 means none) |
| walk_req_valid_o | output | 1 | Walk request |
| walk_req_ready_i | input | 1 | Walker accepts request |
| walk_req_vpn_o | output | VA_W-12 | Page number to walk |
| walk_req_store_o | output | 1 | Walk is for a store |
| walk_req_fetch_o | output | 1 | Walk is for a fetch |
| walk_rsp_valid_i | input | 1 | Walker result present |
| walk_rsp_ppn_i | input | PA_W-12 | Physical page number, all ones for failure |

## Verification
The hardest case to reach is a flush that lands in the same cycle as an install. From the ports this only happens while the walker is answering. The walker model in the bench can therefore raise flush_i in the exact cycle it presents its result. A later access to that page must then walk again. Mixed sequences of loads, stores and fetches on one page and on a conflicting page drive the per-kind keep and invalidate rule through every case.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {FK_NONE = 2'd0, FK_LOAD = 2'd1, FK_STORE = 2'd2, FK_INSN = 2'd3} fault_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ISSUE = 2'd1, ST_WAIT = 2'd2} state_e;

  localparam int unsigned NUM_KINDS = 3;

  function automatic acc_e acc_of(input logic store, input logic fetch);
    if (fetch)      return ACC_FETCH;
    else if (store) return ACC_STORE;
    else            return ACC_LOAD;
  endfunction

  function automatic fault_e fault_of(input acc_e acc);
    case (acc)
      ACC_FETCH: return FK_INSN;
      ACC_STORE: return FK_STORE;
      default:   return FK_LOAD;
    endcase
  endfunction
endpackage

// File: rtl/xlt_tag_bank.sv
module xlt_tag_bank #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned TAG_W   = 27,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  output logic             hit_o,
  input  logic             fill_en_i,
  input  logic             fill_own_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [TAG_W-1:0] fill_tag_i
);
  localparam logic [TAG_W-1:0] INVALID = '1;

  logic [TAG_W-1:0] tags_q [ENTRIES];
  logic [TAG_W-1:0] tags_d [ENTRIES];

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) tags_d[i] = tags_q[i];
    if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) tags_d[i] = INVALID;
    end else if (fill_en_i) begin
      if (tags_q[fill_idx_i] != fill_tag_i) tags_d[fill_idx_i] = INVALID;
      if (fill_own_i)                       tags_d[fill_idx_i] = fill_tag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tags_q[i] <= INVALID;
    end else begin
      for (int i = 0; i < ENTRIES; i++) tags_q[i] <= tags_d[i];
    end
  end

  assign hit_o = (tags_q[rd_idx_i] == rd_tag_i) && (rd_tag_i != INVALID);

  p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !hit_o);
  p_own_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && fill_own_i && !flush_i) |=> tags_q[$past(fill_idx_i)] == $past(fill_tag_i));
  p_match_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !fill_own_i && !flush_i && tags_q[fill_idx_i] == fill_tag_i)
      |=> tags_q[$past(fill_idx_i)] == $past(fill_tag_i));
  p_other_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !fill_own_i && !flush_i && tags_q[fill_idx_i] != fill_tag_i)
      |=> tags_q[$past(fill_idx_i)] == INVALID);
endmodule

// File: rtl/xlt_page_store.sv
module xlt_page_store #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PPN_W   = 22,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PPN_W-1:0] rd_ppn_o
);
  logic [PPN_W-1:0] ppn_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en_i) ppn_q[wr_idx_i] <= wr_ppn_i;
  end

  assign rd_ppn_o = ppn_q[rd_idx_i];
endmodule

// File: rtl/split_xlate_cache.sv
module split_xlate_cache
  import xlt_pkg::*;
#(
  parameter int unsigned VA_W    = 39,
  parameter int unsigned PA_W    = 34,
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned PG_BITS = 12,
  localparam int unsigned VPN_W  = VA_W - PG_BITS,
  localparam int unsigned PPN_W  = PA_W - PG_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             bare_i,
  input  logic             priv_mach_i,
  input  logic             eff_mach_i,
  input  logic [VA_W-1:0]  mem_limit_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_store_i,
  input  logic             req_fetch_i,
  output logic             resp_valid_o,
  output logic [PA_W-1:0]  resp_paddr_o,
  output logic [1:0]       resp_kind_o,
  output logic             walk_req_valid_o,
  input  logic             walk_req_ready_i,
  output logic [VPN_W-1:0] walk_req_vpn_o,
  output logic             walk_req_store_o,
  output logic             walk_req_fetch_o,
  input  logic             walk_rsp_valid_i,
  input  logic [PPN_W-1:0] walk_rsp_ppn_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  state_e            state_q, state_d;
  logic [VA_W-1:0]   cap_vaddr_q;
  logic              cap_store_q, cap_fetch_q;
  logic              cap_en;

  logic [VPN_W-1:0]  req_vpn, cap_vpn;
  logic [IDX_W-1:0]  req_idx, cap_idx;
  acc_e              req_acc, cap_acc;
  logic              bypass, byp_fault, hit_sel, walk_fail, fill_en;
  logic [NUM_KINDS-1:0] hit_v;
  logic [PPN_W-1:0]  rd_ppn;

  assign req_vpn = req_vaddr_i[VA_W-1:PG_BITS];
  assign req_idx = req_vpn[IDX_W-1:0];
  assign req_acc = acc_of(req_store_i, req_fetch_i);
  assign cap_vpn = cap_vaddr_q[VA_W-1:PG_BITS];
  assign cap_idx = cap_vpn[IDX_W-1:0];
  assign cap_acc = acc_of(cap_store_q, cap_fetch_q);

  assign bypass    = bare_i || (priv_mach_i && (eff_mach_i || req_fetch_i));
  assign byp_fault = req_vaddr_i >= mem_limit_i;
  assign walk_fail = &walk_rsp_ppn_i;
  assign fill_en   = (state_q == ST_WAIT) && walk_rsp_valid_i && !walk_fail;

  // one tag bank per access kind
  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_bank
    xlt_tag_bank #(.ENTRIES(ENTRIES), .TAG_W(VPN_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush_i    (flush_i),
      .rd_idx_i   (req_idx),
      .rd_tag_i   (req_vpn),
      .hit_o      (hit_v[g]),
      .fill_en_i  (fill_en),
      .fill_own_i (cap_acc == acc_e'(g)),
      .fill_idx_i (cap_idx),
      .fill_tag_i (cap_vpn)
    );
  end

  xlt_page_store #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_pages (
    .clk      (clk),
    .wr_en_i  (fill_en),
    .wr_idx_i (cap_idx),
    .wr_ppn_i (walk_rsp_ppn_i),
    .rd_idx_i (req_idx),
    .rd_ppn_o (rd_ppn)
  );

  assign hit_sel = hit_v[req_acc];
  assign cap_en  = (state_q == ST_IDLE) && req_valid_i && !bypass && !hit_sel;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (cap_en) state_d = ST_ISSUE;
      ST_ISSUE: if (walk_req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (walk_rsp_valid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cap_vaddr_q <= '0;
      cap_store_q <= 1'b0;
      cap_fetch_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        cap_vaddr_q <= req_vaddr_i;
        cap_store_q <= req_store_i;
        cap_fetch_q <= req_fetch_i;
      end
    end
  end

  always_comb begin
    resp_valid_o = 1'b0;
    resp_paddr_o = '0;
    resp_kind_o  = FK_NONE;
    if (state_q == ST_IDLE) begin
      resp_valid_o = req_valid_i && (bypass || hit_sel);
      if (bypass) begin
        if (byp_fault) resp_kind_o  = fault_of(req_acc);
        else           resp_paddr_o = {req_vaddr_i[PA_W-1:PG_BITS], req_vaddr_i[PG_BITS-1:0]};
      end else begin
        resp_paddr_o = {rd_ppn, req_vaddr_i[PG_BITS-1:0]};
      end
    end else if (state_q == ST_WAIT) begin
      resp_valid_o = walk_rsp_valid_i;
      if (walk_fail) resp_kind_o  = fault_of(cap_acc);
      else           resp_paddr_o = {walk_rsp_ppn_i, cap_vaddr_q[PG_BITS-1:0]};
    end
  end

  assign walk_req_valid_o = (state_q == ST_ISSUE);
  assign walk_req_vpn_o   = cap_vpn;
  assign walk_req_store_o = cap_store_q;
  assign walk_req_fetch_o = cap_fetch_q;

  p_walk_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid_o && !walk_req_ready_i) |=> walk_req_valid_o && $stable(walk_req_vpn_o));
  p_miss_walks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> walk_req_valid_o && walk_req_vpn_o == $past(req_vpn));
  p_bypass_no_walk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req_valid_i && bypass) |=> !walk_req_valid_o);
  p_fault_zero_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && resp_kind_o != FK_NONE) |-> resp_paddr_o == '0);
endmodule

// File: tb/split_xlate_cache_test.sv
`timescale 1ns/1ps
module split_xlate_cache_test;
  localparam int VA_W = 39, PA_W = 34, PG = 12;
  localparam int VPN_W = VA_W - PG, PPN_W = PA_W - PG;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0, bare = 1'b0, pm = 1'b0, em = 1'b0;
  logic [VA_W-1:0] limit = 39'h0_4000_0000;
  logic req_valid = 1'b0, req_st = 1'b0, req_fe = 1'b0;
  logic [VA_W-1:0] req_va = '0;
  logic resp_valid, wreq_valid, wreq_st, wreq_fe;
  logic [PA_W-1:0] resp_pa;
  logic [1:0] resp_kind;
  logic [VPN_W-1:0] wreq_vpn;
  logic wready = 1'b0, wrsp_valid = 1'b0;
  logic [PPN_W-1:0] wrsp_ppn = '0;

  int checks = 0, errors = 0, walks = 0;
  bit flush_with_rsp = 1'b0, done = 1'b0;
  logic [VPN_W-1:0] exp_vpn;
  logic [PA_W-1:0] q_pa[$];
  logic [1:0] q_kind[$];
  string q_tag[$];

  always #2 clk = ~clk;

  split_xlate_cache uut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .bare_i(bare), .priv_mach_i(pm),
    .eff_mach_i(em), .mem_limit_i(limit), .req_valid_i(req_valid), .req_vaddr_i(req_va),
    .req_store_i(req_st), .req_fetch_i(req_fe), .resp_valid_o(resp_valid),
    .resp_paddr_o(resp_pa), .resp_kind_o(resp_kind), .walk_req_valid_o(wreq_valid),
    .walk_req_ready_i(wready), .walk_req_vpn_o(wreq_vpn), .walk_req_store_o(wreq_st),
    .walk_req_fetch_o(wreq_fe), .walk_rsp_valid_i(wrsp_valid), .walk_rsp_ppn_i(wrsp_ppn));

  function automatic bit vpn_faults(input logic [VPN_W-1:0] v);
    return v[15:12] == 4'hD;
  endfunction
  function automatic logic [PPN_W-1:0] vpn_map(input logic [VPN_W-1:0] v);
    return v[PPN_W-1:0] ^ 22'h15A5A;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // walker model
  initial begin
    forever begin
      @(negedge clk);
      if (wreq_valid) begin
        repeat (2) @(negedge clk);
        @(posedge clk); #1 wready = 1'b1;
        check(wreq_vpn == exp_vpn, "R7", "walk vpn", longint'(wreq_vpn), longint'(exp_vpn));
        check(wreq_valid, "R7", "walk valid held", longint'(wreq_valid), 1);
        @(posedge clk); #1 wready = 1'b0;
        walks++;
        repeat (2) @(posedge clk);
        #1 wrsp_valid = 1'b1;
        wrsp_ppn = vpn_faults(exp_vpn) ? '1 : vpn_map(exp_vpn);
        if (flush_with_rsp) flush = 1'b1;
        @(posedge clk); #1 wrsp_valid = 1'b0;
        if (flush_with_rsp) begin flush = 1'b0; flush_with_rsp = 1'b0; end
      end
    end
  end

  // monitor: compare responses with scoreboard
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (q_pa.size() == 0) begin
        check(1'b0, "R2", "unexpected response", longint'(resp_pa), 0);
      end else begin
        logic [PA_W-1:0] ep;
        logic [1:0] ek;
        string t;
        ep = q_pa.pop_front(); ek = q_kind.pop_front(); t = q_tag.pop_front();
        check(resp_kind == ek, t, "fault kind", longint'(resp_kind), longint'(ek));
        check(resp_pa == ep, t, "paddr", longint'(resp_pa), longint'(ep));
      end
    end
  end

  task automatic acc(input logic [VA_W-1:0] va, input logic st, input logic fe,
                     input bit exp_walk, input string tag);
    bit byp, flt;
    logic [PA_W-1:0] ep;
    logic [1:0] ek;
    int w0;
    byp = bare || (pm && (em || fe));
    flt = byp ? (va >= limit) : vpn_faults(va[VA_W-1:PG]);
    ek  = !flt ? 2'd0 : fe ? 2'd3 : st ? 2'd2 : 2'd1;
    ep  = flt ? '0 : byp ? va[PA_W-1:0] : {vpn_map(va[VA_W-1:PG]), va[PG-1:0]};
    q_pa.push_back(ep); q_kind.push_back(ek); q_tag.push_back(tag);
    exp_vpn = va[VA_W-1:PG];
    w0 = walks;
    @(posedge clk); #1;
    req_valid = 1'b1; req_va = va; req_st = st; req_fe = fe;
    do @(negedge clk); while (!resp_valid);
    @(posedge clk); #1 req_valid = 1'b0;
    check((walks - w0) == int'(exp_walk), tag, "walk count", longint'(walks - w0), longint'(exp_walk));
  endtask

  task automatic pulse_flush();
    @(posedge clk); #1 flush = 1'b1;
    @(posedge clk); #1 flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!resp_valid && !wreq_valid, "R1", "idle after reset", longint'({resp_valid, wreq_valid}), 0);

    acc(39'h10_123, 0, 0, 1, "R1");      // cold load misses
    acc(39'h10_456, 0, 0, 0, "R2");      // load hits
    acc(39'h10_789, 1, 0, 1, "R4");      // store tag separate
    acc(39'h10_abc, 0, 0, 0, "R5");      // load tag kept (same page)
    acc(39'h10_def, 1, 0, 0, "R2");      // store now hits
    acc(39'h18_001, 0, 0, 1, "R3");      // conflicting page, same slot
    acc(39'h10_002, 1, 0, 1, "R5");      // store tag was dropped
    acc(39'h18_003, 0, 0, 1, "R5");      // load tag dropped by store fill
    acc(39'h21_010, 1, 1, 1, "R6");      // store+fetch acts as fetch
    acc(39'h21_020, 0, 1, 0, "R6");      // fetch hits
    acc(39'h21_030, 1, 0, 1, "R6");      // store tag never written
    acc(39'h25_040, 1, 0, 1, "R4");      // store fill
    acc(39'h25_050, 0, 1, 1, "R4");      // fetch does not hit on store fill

    acc(39'hD000_100, 0, 0, 1, "R10");   // walker failure, load
    acc(39'hD000_200, 0, 0, 1, "R10");   // nothing installed
    acc(39'hD000_300, 1, 0, 1, "R11");   // store fault code
    acc(39'hD000_400, 0, 1, 1, "R11");   // instruction fault code
    acc(39'hD000_500, 1, 1, 1, "R6");    // both flags fault as instruction

    acc(39'h30_111, 0, 0, 1, "R8");      // install slot 0
    bare = 1'b1;
    acc(39'h1234_5678, 0, 0, 0, "R8");   // bare bypass
    acc(39'h38_222, 0, 0, 0, "R8");      // bypass of conflicting page
    acc(39'h4000_0000, 1, 0, 0, "R9");   // at limit faults
    acc(39'h3FFF_FFFF, 0, 0, 0, "R9");   // just below limit
    acc(39'h4000_0010, 0, 1, 0, "R9");   // fetch fault code in bypass
    bare = 1'b0;
    acc(39'h30_333, 0, 0, 0, "R8");      // tags untouched by bypass
    pm = 1'b1;
    acc(39'h2_0000_0abc, 0, 1, 0, "R8"); // machine fetch bypass
    em = 1'b1;
    acc(39'h0_0777_0123, 1, 0, 0, "R8"); // machine effective data bypass
    em = 1'b0;
    acc(39'h41_444, 0, 0, 1, "R8");      // machine with lower effective: translated
    pm = 1'b0;

    acc(39'h42_010, 0, 0, 1, "R12");
    acc(39'h42_020, 0, 0, 0, "R12");
    pulse_flush();
    acc(39'h42_030, 0, 0, 1, "R12");     // flush cleared it
    flush_with_rsp = 1'b1;
    acc(39'h4A_040, 1, 0, 1, "R12");     // flush lands with install
    acc(39'h4A_050, 1, 0, 1, "R12");     // flush won

    acc({VA_W{1'b1}}, 0, 0, 1, "R13");
    acc({VA_W{1'b1}}, 0, 0, 1, "R13");   // reserved tag never hits

    repeat (4) @(posedge clk);
    check(q_pa.size() == 0, "R7", "responses outstanding", longint'(q_pa.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule